// File: doc/BRIEF.md
# ADC Sampling Sequencer

This block drives a successive-approximation converter core from a programmable list of channel slots. A start strobe launches a pass over the slots from slot 0 up to a programmed last index. Each slot waits an inter-sample delay, then hands the slot's channel number to the converter over a valid/ready request. When the converter returns a result, the block tags it with the channel number and writes it into a result FIFO. In single mode the block goes idle after the last slot. In continuous mode it wraps back to slot 0 and keeps running until stopped.

The host reads a status word and pops tagged results through a valid/ready read port. The read port has first-word fall-through, so a word is visible before it is popped. On the request side the block holds `conv_req_valid` and `conv_req_chan` until the converter accepts. The converter's result is a single-cycle `conv_rsp_valid` pulse with no back-pressure, and the block takes it only while it waits for that result. The host exerts back-pressure by leaving `pop_ready` low. Results that arrive while the FIFO is full are dropped.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is idle with no request pending. The status word is 0x0400_0000: only the FIFO-empty bit is set and the current-channel field shows slot 0, which is zero in the reset test. `irq` and `pop_valid` are low.
- R2: When `eng_enable` is high, a start strobe sets sample-busy (status bit 28) in the status word sampled one clock later. With `eng_enable` low the strobe is ignored and no request follows. A start strobe while the block is busy has no effect.
- R3: Before each slot's request the block waits (`dly_count`+1) × 4^`dly_base` clocks, with delta-busy (status bit 30) high. Counted from the clock edge that samples the start strobe, `conv_req_valid` rises after (`dly_count`+1) × 4^`dly_base` + 1 edges.
- R4: Slot k holds its channel in `chan_list` bits 3k+2:3k. Slots are requested in order 0 to `max_index`. While slot k is active, `conv_req_chan` and the current-channel field (status bits 18:16) both show slot k's channel.
- R5: In single mode (`cont_mode` low), once the result for slot `max_index` is stored, status bits 30:28 are all zero and no further request is issued.
- R6: In continuous mode, the slot after `max_index` is slot 0, and this repeats until a stop.
- R7: Each FIFO word carries the channel in bits 14:12 and the converter value in bits 11:0. Words pop in the order they were stored.
- R8: Status bit 27 is FIFO full and status bit 26 is FIFO empty. Bits 25:21 hold the low five bits of the occupancy, so a full 32-entry FIFO reads 0 there.
- R9: With the FIFO empty, `pop_valid` is low and `pop_data` is zero. A pop attempt leaves the count at zero.
- R10: A result that arrives while the FIFO is full is dropped. The full flag stays set and the stored words are unchanged.
- R11: A stop during the delay returns the block to idle at the next clock. A stop while a conversion is outstanding keeps the block busy until that result is stored; then all three busy bits clear together.
- R12: `irq` is high exactly when `fifo_irq_en` is high and the occupancy is at least `irq_thresh`.
- R13: While `conv_req_valid` is high and `conv_req_ready` is low, the request and its channel stay stable. Averaging-busy (status bit 29) is high from the request until the result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_enable | input | 1 | Allows start strobes to launch a run |
| cont_mode | input | 1 | 1: wrap to slot 0 after the last slot |
| start_strobe | input | 1 | One-cycle start pulse |
| stop_strobe | input | 1 | One-cycle stop pulse |
| chan_list | input | 24 | Eight 3-bit slot channel selections |
| max_index | input | 3 | Index of the last slot used |
| dly_count | input | 8 | Inter-sample delay count |
| dly_base | input | 2 | Delay time base, 4^n clocks per unit |
| fifo_irq_en | input | 1 | Enables the occupancy interrupt |
| irq_thresh | input | 5 | Occupancy threshold for the interrupt |
| conv_req_valid | output | 1 | Conversion request to the converter |
| conv_req_ready | input | 1 | Converter accepts the request |
| conv_req_chan | output | 3 | Channel to convert |
| conv_rsp_valid | input | 1 | Converter result pulse |
| conv_rsp_data | input | 12 | Converter result value |
| pop_valid | output | 1 | A result word is available |
| pop_ready | input | 1 | Host pops the head word |
| pop_data | output | 15 | Head word: channel in 14:12, value in 11:0 |
| status | output | 32 | Busy flags, FIFO flags, count and current channel |
| irq | output | 1 | Occupancy interrupt |

## Verification
Each result has its own due time. The busy bits appear in the status sampled on the falling edge after the edge that takes a strobe. The request appears a fixed number of edges later, given by the R3 formula. A stored result shows in count, flags, `pop_data` and `irq` on the falling edge after the edge that took the converter pulse. The bench drives every input and samples every output on the falling edge. It counts edges explicitly to compare the delay against the formula. The converter model answers two clocks after the handshake, so the cycles in which the block waits for a result are known in advance, and the stop-while-converting case hits that window on purpose.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 3;

  // status word bit positions
  localparam int ST_DELTA_BUSY  = 30;
  localparam int ST_AVG_BUSY    = 29;
  localparam int ST_SAMPLE_BUSY = 28;
  localparam int ST_FULL        = 27;
  localparam int ST_EMPTY       = 26;
  localparam int ST_CNT_LO      = 21;
  localparam int ST_CNT_W       = 5;
  localparam int ST_CHAN_LO     = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_REQ   = 2'd2,
    SEQ_WAIT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int DATA_W     = 12,
  parameter int DLY_W      = 8,
  parameter int BASE_SHIFT = 2,
  localparam int IDX_W     = $clog2(SLOTS),
  localparam int TMR_W     = DLY_W + 3 * BASE_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    continuous,
  input  logic                    start,
  input  logic                    stop,
  input  logic [SLOTS*CH_W-1:0]   chan_list,
  input  logic [IDX_W-1:0]        max_index,
  input  logic [DLY_W-1:0]        dly_count,
  input  logic [1:0]              dly_base,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [CH_W-1:0]         req_chan,
  input  logic                    rsp_valid,
  input  logic [DATA_W-1:0]       rsp_data,
  output logic                    push_valid,
  output logic [CH_W+DATA_W-1:0]  push_word,
  output logic                    busy_sample,
  output logic                    busy_avg,
  output logic                    busy_delta,
  output logic [CH_W-1:0]         cur_chan
);
  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [TMR_W-1:0] tmr;
  logic             stop_pend;
  logic [TMR_W:0]   dly_total;
  logic [TMR_W:0]   dly_total_m1;

  logic [CH_W-1:0] slot_chan [SLOTS];
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot_chan[k] = chan_list[k*CH_W +: CH_W];
  end

  always_comb begin
    dly_total    = ({{(TMR_W+1-DLY_W){1'b0}}, dly_count} + (TMR_W+1)'(1))
                   << (BASE_SHIFT * int'(dly_base));
    dly_total_m1 = dly_total - (TMR_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      idx       <= '0;
      tmr       <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start && enable) begin
            state     <= SEQ_DELAY;
            idx       <= '0;
            tmr       <= dly_total_m1[TMR_W-1:0];
            stop_pend <= 1'b0;
          end
        end
        SEQ_DELAY: begin
          if (stop)            state <= SEQ_IDLE;
          else if (tmr == '0)  state <= SEQ_REQ;
          else                 tmr   <= tmr - 1'b1;
        end
        SEQ_REQ: begin
          stop_pend <= stop_pend | stop;
          if (req_ready) state <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          stop_pend <= stop_pend | stop;
          if (rsp_valid) begin
            if (stop_pend || stop) begin
              state <= SEQ_IDLE;
            end else if (idx == max_index) begin
              if (continuous) begin
                idx   <= '0;
                tmr   <= dly_total_m1[TMR_W-1:0];
                state <= SEQ_DELAY;
              end else begin
                state <= SEQ_IDLE;
              end
            end else begin
              idx   <= idx + 1'b1;
              tmr   <= dly_total_m1[TMR_W-1:0];
              state <= SEQ_DELAY;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign cur_chan    = slot_chan[idx];
  assign req_valid   = (state == SEQ_REQ);
  assign req_chan    = cur_chan;
  assign push_valid  = (state == SEQ_WAIT) && rsp_valid;
  assign push_word   = {cur_chan, rsp_data};
  assign busy_sample = (state != SEQ_IDLE);
  assign busy_avg    = (state == SEQ_REQ) || (state == SEQ_WAIT);
  assign busy_delta  = (state == SEQ_DELAY);
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 15,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_word,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [WIDTH-1:0] pop_word,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             do_push;
  logic             do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push_valid && !full;
  assign do_pop  = pop_ready && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign pop_valid = !empty;
  assign pop_word  = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             busy_delta,
  input  logic             busy_avg,
  input  logic             busy_sample,
  input  logic             full,
  input  logic             empty,
  input  logic [CNT_W-1:0] count,
  input  logic [CH_W-1:0]  cur_chan,
  input  logic             irq_en,
  input  logic [ST_CNT_W-1:0] irq_thresh,
  output logic [31:0]      status,
  output logic             irq
);
  always_comb begin
    status = '0;
    status[ST_DELTA_BUSY]  = busy_delta;
    status[ST_AVG_BUSY]    = busy_avg;
    status[ST_SAMPLE_BUSY] = busy_sample;
    status[ST_FULL]        = full;
    status[ST_EMPTY]       = empty;
    status[ST_CNT_LO +: ST_CNT_W] = count[ST_CNT_W-1:0];
    status[ST_CHAN_LO +: CH_W]    = cur_chan;
  end

  assign irq = irq_en && (count >= CNT_W'(irq_thresh));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int DATA_W     = 12,
  parameter int DLY_W      = 8,
  parameter int FIFO_DEPTH = 32,
  localparam int IDX_W     = $clog2(SLOTS),
  localparam int WORD_W    = CH_W + DATA_W,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eng_enable,
  input  logic                   cont_mode,
  input  logic                   start_strobe,
  input  logic                   stop_strobe,
  input  logic [SLOTS*CH_W-1:0]  chan_list,
  input  logic [IDX_W-1:0]       max_index,
  input  logic [DLY_W-1:0]       dly_count,
  input  logic [1:0]             dly_base,
  input  logic                   fifo_irq_en,
  input  logic [ST_CNT_W-1:0]    irq_thresh,
  output logic                   conv_req_valid,
  input  logic                   conv_req_ready,
  output logic [CH_W-1:0]        conv_req_chan,
  input  logic                   conv_rsp_valid,
  input  logic [DATA_W-1:0]      conv_rsp_data,
  output logic                   pop_valid,
  input  logic                   pop_ready,
  output logic [WORD_W-1:0]      pop_data,
  output logic [31:0]            status,
  output logic                   irq
);
  logic              push_valid;
  logic [WORD_W-1:0] push_word;
  logic              busy_sample, busy_avg, busy_delta;
  logic [CH_W-1:0]   cur_chan;
  logic [CNT_W-1:0]  count;
  logic              full, empty;

  adc_seq_ctrl #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .DLY_W(DLY_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(eng_enable), .continuous(cont_mode),
    .start(start_strobe), .stop(stop_strobe), .chan_list(chan_list),
    .max_index(max_index), .dly_count(dly_count), .dly_base(dly_base),
    .req_valid(conv_req_valid), .req_ready(conv_req_ready),
    .req_chan(conv_req_chan), .rsp_valid(conv_rsp_valid),
    .rsp_data(conv_rsp_data), .push_valid(push_valid), .push_word(push_word),
    .busy_sample(busy_sample), .busy_avg(busy_avg), .busy_delta(busy_delta),
    .cur_chan(cur_chan)
  );

  adc_seq_fifo #(
    .DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)
  ) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_word(pop_data),
    .count(count), .full(full), .empty(empty)
  );

  adc_seq_status #(
    .CNT_W(CNT_W)
  ) status_i (
    .busy_delta(busy_delta), .busy_avg(busy_avg), .busy_sample(busy_sample),
    .full(full), .empty(empty), .count(count), .cur_chan(cur_chan),
    .irq_en(fifo_irq_en), .irq_thresh(irq_thresh),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int WORD_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_enable,
  input logic              start_strobe,
  input logic              conv_req_valid,
  input logic              conv_req_ready,
  input logic [2:0]        conv_req_chan,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic [WORD_W-1:0] pop_data,
  input logic [2:0]        busy_bits,
  input logic              full_bit,
  input logic              empty_bit,
  input logic              fifo_irq_en,
  input logic              irq
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe && eng_enable && !busy_bits[0] |=> busy_bits[0]); // R2
  AST_DELAY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy_bits[2] |-> !conv_req_valid); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_bit && empty_bit)); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid |-> (pop_data == '0) && empty_bit); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full_bit && !(pop_valid && pop_ready) |=> full_bit); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_bits[0] |-> !conv_req_valid && (busy_bits[2:1] == 2'b00)); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_irq_en |-> !irq); // R12
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid && !conv_req_ready |=> conv_req_valid && $stable(conv_req_chan)); // R13
endmodule

bind adc_seq_top adc_seq_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .eng_enable(eng_enable),
  .start_strobe(start_strobe), .conv_req_valid(conv_req_valid),
  .conv_req_ready(conv_req_ready), .conv_req_chan(conv_req_chan),
  .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
  .busy_bits(status[30:28]), .full_bit(status[27]), .empty_bit(status[26]),
  .fifo_irq_en(fifo_irq_en), .irq(irq)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eng_enable, cont_mode, start_strobe, stop_strobe;
  logic [23:0] chan_list;
  logic [2:0]  max_index;
  logic [7:0]  dly_count;
  logic [1:0]  dly_base;
  logic        fifo_irq_en;
  logic [4:0]  irq_thresh;
  logic        conv_req_valid, conv_req_ready;
  logic [2:0]  conv_req_chan;
  logic        conv_rsp_valid;
  logic [11:0] conv_rsp_data;
  logic        pop_valid, pop_ready;
  logic [14:0] pop_data;
  logic [31:0] status;
  logic        irq;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  adc_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .eng_enable(eng_enable), .cont_mode(cont_mode),
    .start_strobe(start_strobe), .stop_strobe(stop_strobe),
    .chan_list(chan_list), .max_index(max_index), .dly_count(dly_count),
    .dly_base(dly_base), .fifo_irq_en(fifo_irq_en), .irq_thresh(irq_thresh),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_req_chan(conv_req_chan), .conv_rsp_valid(conv_rsp_valid),
    .conv_rsp_data(conv_rsp_data), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_data(pop_data), .status(status), .irq(irq)
  );

  // converter model: answers two clocks after the request handshake
  int          pend = 0;
  int          conv_n = 0;
  logic [2:0]  cap_chan;
  logic [14:0] exp_q [$];

  initial begin
    conv_rsp_valid = 1'b0;
    conv_rsp_data  = '0;
    cap_chan       = '0;
    forever begin
      @(negedge clk);
      #1;
      conv_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          conv_rsp_data  = 12'((int'(cap_chan) << 8) | (conv_n & 255));
          conv_rsp_valid = 1'b1;
          exp_q.push_back({cap_chan, conv_rsp_data});
          conv_n++;
        end
      end else if (rst_n && conv_req_valid && conv_req_ready) begin
        cap_chan = conv_req_chan;
        pend     = 2;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_strobe = 1'b1;
    @(negedge clk);
    start_strobe = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_strobe = 1'b1;
    @(negedge clk);
    stop_strobe = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && status[28]; i++) @(negedge clk);
  endtask

  task automatic pop_one(output logic [14:0] w, output logic v);
    v = pop_valid;
    w = pop_data;
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  task automatic drain();
    logic [14:0] w;
    logic v;
    for (int i = 0; i < 40 && pop_valid; i++) pop_one(w, v);
    exp_q.delete();
  endtask

  // returns edges counted until the request shows, starting at the strobe edge
  task automatic measure_req(output int n);
    n = 1;
    while (!conv_req_valid && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0400_0000);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 req_valid", {31'b0, conv_req_valid}, 0);
    chk("R1 pop_valid", {31'b0, pop_valid}, 0);
  endtask

  task automatic t_start_disabled();
    eng_enable = 1'b0;
    pulse_start();
    chk("R2 disabled busy", {31'b0, status[28]}, 0);
    cyc(4);
    chk("R2 disabled no request", {31'b0, conv_req_valid}, 0);
    eng_enable = 1'b1;
  endtask

  task automatic t_single();
    int n;
    int seen;
    logic [14:0] w;
    logic v;
    logic [2:0] order [3];
    order[0] = 3'd5; order[1] = 3'd2; order[2] = 3'd7;
    cont_mode = 1'b0;
    chan_list = 24'd469;          // slot0=5, slot1=2, slot2=7
    max_index = 3'd2;
    dly_count = 8'd1;
    dly_base  = 2'd0;
    pulse_start();
    chk("R2 busy after start", {31'b0, status[28]}, 1);
    chk("R3 delta busy in delay", {31'b0, status[30]}, 1);
    measure_req(n);
    chk("R3 delay edges count=1 base=0", n, 3);
    chk("R4 first request channel", {29'b0, conv_req_chan}, 5);
    chk("R4 current channel field", {29'b0, status[18:16]}, 5);
    start_strobe = 1'b1;           // start while busy: ignored (R2)
    @(negedge clk);
    start_strobe = 1'b0;
    wait_idle();
    chk("R5 busy bits clear", {29'b0, status[30:28]}, 0);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (conv_req_valid) seen++;
    end
    chk("R5 no request after last slot", seen, 0);
    chk("R8 count field", {27'b0, status[25:21]}, 3);
    chk("R8 empty clear", {31'b0, status[26]}, 0);
    fifo_irq_en = 1'b1;
    irq_thresh  = 5'd3;
    #0.1;
    chk("R12 irq at threshold", {31'b0, irq}, 1);
    irq_thresh = 5'd4;
    #0.1;
    chk("R12 irq below threshold", {31'b0, irq}, 0);
    irq_thresh  = 5'd3;
    fifo_irq_en = 1'b0;
    #0.1;
    chk("R12 irq disabled", {31'b0, irq}, 0);
    fifo_irq_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pop_one(w, v);
      chk("R7 popped valid", {31'b0, v}, 1);
      chk("R4 slot order tag", {29'b0, w[14:12]}, {29'b0, order[i]});
      if (exp_q.size() > 0) chk("R7 tagged word", {17'b0, w}, {17'b0, exp_q.pop_front()});
      else chk("R7 expected word present", 0, 1);
      if (i == 0) chk("R12 irq after pop", {31'b0, irq}, 0);
    end
    fifo_irq_en = 1'b0;
    chk("R8 empty after pops", {31'b0, status[26]}, 1);
  endtask

  task automatic t_pop_empty();
    logic [14:0] w;
    logic v;
    pop_one(w, v);
    chk("R9 empty pop data", {17'b0, w}, 0);
    chk("R9 empty pop valid", {31'b0, v}, 0);
    chk("R9 count unchanged", {27'b0, status[25:21]}, 0);
  endtask

  task automatic t_base();
    int n;
    logic [14:0] w;
    logic v;
    cont_mode = 1'b0;
    chan_list = 24'd4;
    max_index = 3'd0;
    dly_count = 8'd0;
    dly_base  = 2'd1;
    pulse_start();
    chk("R4 current channel in delay", {29'b0, status[18:16]}, 4);
    measure_req(n);
    chk("R3 delay edges count=0 base=1", n, 5);
    wait_idle();
    pop_one(w, v);
    if (exp_q.size() > 0) chk("R7 single word", {17'b0, w}, {17'b0, exp_q.pop_front()});
    else chk("R7 expected word present", 0, 1);
  endtask

  task automatic t_hold();
    int n;
    chan_list = 24'd6;
    max_index = 3'd0;
    dly_count = 8'd0;
    dly_base  = 2'd0;
    conv_req_ready = 1'b0;
    pulse_start();
    measure_req(n);
    chk("R13 avg busy with request", {31'b0, status[29]}, 1);
    cyc(4);
    chk("R13 request held", {31'b0, conv_req_valid}, 1);
    chk("R13 channel held", {29'b0, conv_req_chan}, 6);
    conv_req_ready = 1'b1;
    cyc(2);
    chk("R13 avg busy until result", {31'b0, status[29]}, 1);
    wait_idle();
    drain();
  endtask

  task automatic t_continuous();
    logic [2:0] got [5];
    logic [4:0] c0;
    cont_mode = 1'b1;
    chan_list = 24'd51;            // slot0=3, slot1=6
    max_index = 3'd1;
    dly_count = 8'd2;
    dly_base  = 2'd0;
    pulse_start();
    for (int i = 0; i < 5; i++) begin
      for (int t = 0; t < 1000 && !conv_req_valid; t++) @(negedge clk);
      got[i] = conv_req_chan;
      @(negedge clk);
    end
    chk("R6 wrap sequence 0", {29'b0, got[0]}, 3);
    chk("R6 wrap sequence 1", {29'b0, got[1]}, 6);
    chk("R6 wrap sequence 2", {29'b0, got[2]}, 3);
    chk("R6 wrap sequence 3", {29'b0, got[3]}, 6);
    chk("R6 wrap sequence 4", {29'b0, got[4]}, 3);
    chk("R11 waiting for result", {30'b0, status[29], conv_req_valid}, 2);
    c0 = status[25:21];
    pulse_stop();
    chk("R11 still busy after stop", {30'b0, status[29:28]}, 3);
    wait_idle();
    chk("R11 busy bits clear", {29'b0, status[30:28]}, 0);
    chk("R11 in-flight result stored", {27'b0, status[25:21]}, {27'b0, c0 + 5'd1});
    cont_mode = 1'b0;
    drain();
  endtask

  task automatic t_stop_delay();
    chan_list = 24'd1;
    max_index = 3'd0;
    dly_count = 8'd200;
    dly_base  = 2'd0;
    pulse_start();
    cyc(3);
    pulse_stop();
    chk("R11 stop in delay idles", {29'b0, status[30:28]}, 0);
    cyc(3);
    chk("R11 no conversion after stop", {27'b0, status[25:21]}, 0);
  endtask

  task automatic t_overflow();
    logic [14:0] w;
    logic [14:0] first;
    logic v;
    int pops;
    exp_q.delete();
    cont_mode = 1'b1;
    chan_list = 24'd2;
    max_index = 3'd0;
    dly_count = 8'd0;
    dly_base  = 2'd0;
    pulse_start();
    for (int i = 0; i < 2000 && !status[27]; i++) @(negedge clk);
    chk("R8 full flag", {31'b0, status[27]}, 1);
    cyc(30);
    chk("R10 full held", {31'b0, status[27]}, 1);
    chk("R8 count field wraps at full", {27'b0, status[25:21]}, 0);
    pulse_stop();
    wait_idle();
    first = (exp_q.size() > 0) ? exp_q[0] : 15'h7fff;
    pop_one(w, v);
    chk("R10 head word unchanged", {17'b0, w}, {17'b0, first});
    pops = 1;
    while (pop_valid && pops < 40) begin
      pop_one(w, v);
      pops++;
    end
    chk("R10 stored words", pops, 32);
    cont_mode = 1'b0;
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    eng_enable = 1'b1; cont_mode = 1'b0;
    start_strobe = 1'b0; stop_strobe = 1'b0;
    chan_list = '0; max_index = '0; dly_count = '0; dly_base = '0;
    fifo_irq_en = 1'b0; irq_thresh = '0;
    conv_req_ready = 1'b1; pop_ready = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_disabled();
    t_single();
    t_pop_empty();
    t_base();
    t_hold();
    t_continuous();
    t_stop_delay();
    t_overflow();
    summary();
    $finish;
  end
endmodule